// File: doc/BRIEF.md
# SPI Packet Master

This block is a register-programmed SPI master that moves a run of bytes in one command. The run length is a packet size times a repeat count. Software places outgoing bytes in a 32-byte transmit FIFO and collects incoming bytes from a 32-byte receive FIFO. Both FIFOs are accessed as 32-bit words through a single-cycle register write/read port. The serial clock, the chip-select timing, the clock mode and the bit and byte ordering are all set by registers.

Each run ends in one of two ways. In the normal case, chip select is released and the block returns to idle after an idle gap, and it signals a finish event. In pause mode, chip select stays asserted and the block parks in a paused state, and it signals a pause event. A resume command then continues on the same chip-select assertion, which lets software chain several runs into one bus transaction. A level interrupt reports either event. Reading the status register clears both the status and the interrupt.

Register word addresses (`reg_addr`):
- 0, clock timing: [7:0] SCK active-level time, [15:8] SCK idle-level time, [23:16] CS hold time, [31:24] CS setup time.
- 1, run shape: [9:0] packet length, [23:16] repeat count, [31:24] CS idle time.
- 2, command.
- 3, transmit word (write).
- 4, receive word (read, pops the FIFO).
- 5, status (read, clears on read).

Every time and count field is stored as its value minus one.

Top module: `spi_pkt_master`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, irq is 0 and the status register (address 5) reads 0.
- R2: Within each bit, sck first spends (idle-level field + 1) clocks at the CPOL level and then (active-level field + 1) clocks at the opposite level.
- R3: Timing of chip select around a run:
  - After a start command, cs_n stays low for (setup field + 1) clocks before the first bit begins.
  - After the last bit, cs_n stays low for (hold field + 1) more clocks.
  - cs_n then stays high for (idle field + 1) clocks before the finish event.
- R4: One run transfers (packet length field + 1) × (repeat field + 1) bytes.
- R5: Clock mode is set by command bits 9 (CPOL) and 8 (CPHA):
  - sck rests at CPOL.
  - With CPHA = 0, mosi changes at the start of a bit and miso is sampled on the leading edge.
  - With CPHA = 1, mosi changes on the leading edge and miso is sampled on the trailing edge.
- R6: Command bit 12 selects MSB-first for transmit and bit 13 selects MSB-first for receive, independently. When a bit is clear, that direction is LSB-first.
- R7: Byte lanes within a FIFO word. By default the first byte on the wire is word bits [7:0]. Command bit 15 reverses this lane order for transmit and bit 14 reverses it for receive.
- R8: Command bits 0, 1 and 2 act as commands:
  - Bit 0 starts a run only from idle.
  - Bit 1 resumes only from paused; in idle it has no effect.
  - Bit 2 is a soft reset. It returns the block to idle with cs_n high, empties both FIFOs and clears the status.
- R9: With pause-enable (command bit 4) set, chip select stays low after the hold time and the block enters the paused state. It then raises status bit 1, not status bit 0.
- R10: Status bit 0 marks a finish and bit 1 marks a pause. A status read returns the bits and clears them, and irq drops on the next clock.
- R11: irq = (status bit 0 AND command bit 16) OR (status bit 1 AND command bit 17). A masked event still sets its status bit.
- R12: A final partial receive word is zero-padded and pushed at the end of a run. The unused bytes of a partly sent transmit word are discarded at the end of a run. Reading an empty receive FIFO returns 0. When the transmit FIFO is empty, zero bytes are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops receive data, clears status) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_re |
| irq | output | 1 | Level interrupt |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
On every cycle, the assertions check the command rules:
- A start from idle asserts chip select.
- A resume in idle leaves it released.
- The paused state holds chip select until resumed.
- A soft reset always releases it.

They also check that a pause event leads into the paused state, that a status read clears the status, and that a status bit rises only after its event. The transmit byte pointer is checked to be retired at the end of a run, and the FIFOs are checked never to overflow.

Only the bench's scenarios can show the exact clock counts of the SCK halves and of the chip-select setup, hold and idle windows. The same goes for the data produced by each combination of clock mode, bit order and lane order in loopback, for runs split over several packets, and for word padding across runs.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  localparam int TIME_W = 8;
  localparam int LEN_W  = 10;
  localparam int LOOP_W = 8;

  localparam logic [2:0] A_CLK  = 3'd0;
  localparam logic [2:0] A_RUN  = 3'd1;
  localparam logic [2:0] A_CMD  = 3'd2;
  localparam logic [2:0] A_TX   = 3'd3;
  localparam logic [2:0] A_RX   = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_PAUSED, ST_GAP
  } seq_state_e;

  // byte taken from a FIFO word; swap reverses lane order
  function automatic logic [7:0] word_byte(input logic [31:0] w, input logic [1:0] idx,
                                           input logic swap);
    logic [31:0] s;
    s = w >> {(swap ? ~idx : idx), 3'b000};
    return s[7:0];
  endfunction

  // byte placed into a FIFO word lane
  function automatic logic [31:0] word_put(input logic [31:0] w, input logic [7:0] b,
                                           input logic [1:0] idx, input logic swap);
    logic [4:0] sh;
    sh = {(swap ? ~idx : idx), 3'b000};
    return (w & ~(32'h0000_00FF << sh)) | ({24'd0, b} << sh);
  endfunction

  // n-th bit on the wire of a byte
  function automatic logic byte_bit(input logic [7:0] b, input logic [2:0] n, input logic msb);
    return msb ? b[~n] : b[n];
  endfunction

  // shift one received bit into a byte
  function automatic logic [7:0] byte_shift(input logic [7:0] b, input logic d, input logic msb);
    return msb ? {b[6:0], d} : {d, b[7:1]};
  endfunction
endpackage

// File: rtl/spi_pkt_fifo.sv
module spi_pkt_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign dout  = mem[rd_q];

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else if (clr) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + AW'(1);
      if (do_pop)  rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (cnt_q == $past(cnt_q))); // R12
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R12
endmodule

// File: rtl/spi_pkt_seq.sv
module spi_pkt_seq
  import spi_pkt_pkg::*;
#(
  parameter int TW = TIME_W,
  parameter int LW = LEN_W,
  parameter int PW = LOOP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          go_start,
  input  logic          go_resume,
  input  logic [TW-1:0] sck_act,
  input  logic [TW-1:0] sck_idl,
  input  logic [TW-1:0] cs_setup,
  input  logic [TW-1:0] cs_hold,
  input  logic [TW-1:0] cs_idle,
  input  logic [LW-1:0] pkt_len,
  input  logic [PW-1:0] loops,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          tx_msb,
  input  logic          rx_msb,
  input  logic          pause_en,
  input  logic [7:0]    tx_byte,
  output logic          tx_take,
  output logic [7:0]    rx_byte,
  output logic          rx_put,
  output logic          run_end,
  output logic          fin_evt,
  output logic          pause_evt,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  seq_state_e    state_q;
  logic [TW-1:0] cnt_q;
  logic          half_q;
  logic [2:0]    bit_q;
  logic [LW-1:0] byte_cnt_q, len_q;
  logic [PW-1:0] loop_cnt_q, loops_q;
  logic [7:0]    txb_q, rxsh_q;
  logic          mosi_q;

  // named internal events
  logic tick, begin_bits, lead_edge, trail_edge, byte_done, last_byte;
  logic [7:0] sample_val;

  assign tick       = (cnt_q == '0);
  assign begin_bits = !soft_rst && (((state_q == ST_SETUP) && tick) ||
                                    ((state_q == ST_PAUSED) && go_resume));
  assign lead_edge  = (state_q == ST_SHIFT) && !half_q && tick;
  assign trail_edge = (state_q == ST_SHIFT) && half_q && tick;
  assign byte_done  = trail_edge && (bit_q == 3'd7);
  assign last_byte  = (byte_cnt_q == len_q) && (loop_cnt_q == loops_q);
  assign sample_val = byte_shift(rxsh_q, miso, rx_msb);

  assign tx_take   = begin_bits || (byte_done && !last_byte);
  assign rx_put    = byte_done;
  assign rx_byte   = cpha ? sample_val : rxsh_q;
  assign run_end   = byte_done && last_byte;
  assign fin_evt   = (state_q == ST_GAP) && tick;
  assign pause_evt = (state_q == ST_HOLD) && tick && pause_en;

  assign cs_n = (state_q == ST_IDLE) || (state_q == ST_GAP);
  assign sck  = ((state_q == ST_SHIFT) && half_q) ? ~cpol : cpol;
  assign mosi = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; half_q <= 1'b0; bit_q <= '0;
      byte_cnt_q <= '0; loop_cnt_q <= '0; len_q <= '0; loops_q <= '0;
      txb_q <= '0; rxsh_q <= '0; mosi_q <= 1'b0;
    end else if (soft_rst) begin
      state_q <= ST_IDLE; cnt_q <= '0; half_q <= 1'b0; bit_q <= '0;
    end else if (begin_bits) begin
      state_q    <= ST_SHIFT;
      half_q     <= 1'b0;
      cnt_q      <= sck_idl;
      bit_q      <= '0;
      txb_q      <= tx_byte;
      byte_cnt_q <= '0;
      loop_cnt_q <= '0;
      len_q      <= pkt_len;
      loops_q    <= loops;
      if (!cpha) mosi_q <= byte_bit(tx_byte, 3'd0, tx_msb);
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_start) begin
          state_q <= ST_SETUP;
          cnt_q   <= cs_setup;
        end
        ST_SETUP, ST_GAP: begin
          if (!tick) cnt_q <= cnt_q - TW'(1);
          else if (state_q == ST_GAP) state_q <= ST_IDLE;
        end
        ST_PAUSED: ;
        ST_HOLD: begin
          if (!tick) cnt_q <= cnt_q - TW'(1);
          else if (pause_en) state_q <= ST_PAUSED;
          else begin
            state_q <= ST_GAP;
            cnt_q   <= cs_idle;
          end
        end
        ST_SHIFT: begin
          if (!tick) begin
            cnt_q <= cnt_q - TW'(1);
          end else if (!half_q) begin
            half_q <= 1'b1;
            cnt_q  <= sck_act;
            if (cpha) mosi_q <= byte_bit(txb_q, bit_q, tx_msb);
            else      rxsh_q <= sample_val;
          end else begin
            if (cpha) rxsh_q <= sample_val;
            half_q <= 1'b0;
            if (bit_q != 3'd7) begin
              bit_q <= bit_q + 3'd1;
              cnt_q <= sck_idl;
              if (!cpha) mosi_q <= byte_bit(txb_q, bit_q + 3'd1, tx_msb);
            end else if (last_byte) begin
              state_q <= ST_HOLD;
              cnt_q   <= cs_hold;
            end else begin
              bit_q <= '0;
              cnt_q <= sck_idl;
              txb_q <= tx_byte;
              if (!cpha) mosi_q <= byte_bit(tx_byte, 3'd0, tx_msb);
              if (byte_cnt_q == len_q) begin
                byte_cnt_q <= '0;
                loop_cnt_q <= loop_cnt_q + PW'(1);
              end else begin
                byte_cnt_q <= byte_cnt_q + LW'(1);
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_START_ASSERTS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && go_start && !soft_rst) |=> !cs_n); // R8
  AST_RESUME_IDLE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && go_resume && !go_start && !soft_rst) |=> cs_n); // R8
  AST_SOFT_RST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cs_n && state_q == ST_IDLE)); // R8
  AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_evt && !soft_rst) |=> (state_q == ST_PAUSED && !cs_n)); // R9
  AST_PAUSE_HOLDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAUSED && !go_resume && !soft_rst) |=> (state_q == ST_PAUSED && !cs_n)); // R9
  AST_LEAD_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_edge && !soft_rst) |=> (state_q == ST_SHIFT && half_q)); // R2
endmodule

// File: rtl/spi_pkt_master.sv
module spi_pkt_master
  import spi_pkt_pkg::*;
#(
  parameter int FIFO_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  localparam int WORDS = FIFO_BYTES / 4;

  logic [31:0] clk_cfg_q, run_cfg_q, cmd_q;
  logic [1:0]  status_q;
  logic [1:0]  txp_q, rxp_q;
  logic [31:0] rx_acc_q;

  logic go_start, go_resume, soft_rst, rd_stat, wr_tx, rd_rx;
  logic tx_take, rx_put, run_end, fin_evt, pause_evt;
  logic [7:0]  tx_byte, rx_byte;
  logic [31:0] tx_head, rx_head, rx_merged;
  logic tx_empty, tx_full, rx_empty, rx_full, tx_pop, rx_push;

  wire wr_cmd = reg_we && (reg_addr == A_CMD);
  assign go_start  = wr_cmd && reg_wdata[0];
  assign go_resume = wr_cmd && reg_wdata[1];
  assign soft_rst  = wr_cmd && reg_wdata[2];
  assign rd_stat   = reg_re && (reg_addr == A_STAT);
  assign wr_tx     = reg_we && (reg_addr == A_TX) && !tx_full;
  assign rd_rx     = reg_re && (reg_addr == A_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cfg_q <= '0; run_cfg_q <= '0; cmd_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_CLK) clk_cfg_q <= reg_wdata;
      if (reg_addr == A_RUN) run_cfg_q <= reg_wdata;
      if (reg_addr == A_CMD) cmd_q     <= {reg_wdata[31:3], 3'b000};
    end
  end

  // transmit byte lane walk
  assign tx_byte = tx_empty ? 8'h00 : word_byte(tx_head, txp_q, cmd_q[15]);
  assign tx_pop  = (tx_take && !tx_empty && (txp_q == 2'd3)) || (run_end && (txp_q != 2'd0));

  // receive byte lane fill
  assign rx_merged = word_put(rx_acc_q, rx_byte, rxp_q, cmd_q[14]);
  assign rx_push   = rx_put && ((rxp_q == 2'd3) || run_end) && !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txp_q <= '0; rxp_q <= '0; rx_acc_q <= '0; status_q <= '0;
    end else if (soft_rst) begin
      txp_q <= '0; rxp_q <= '0; rx_acc_q <= '0; status_q <= '0;
    end else begin
      if (run_end) txp_q <= 2'd0;
      else if (tx_take && !tx_empty) txp_q <= txp_q + 2'd1;
      if (rx_put) begin
        if ((rxp_q == 2'd3) || run_end) begin
          rx_acc_q <= '0;
          rxp_q    <= 2'd0;
        end else begin
          rx_acc_q <= rx_merged;
          rxp_q    <= rxp_q + 2'd1;
        end
      end
      status_q[0] <= fin_evt   || (status_q[0] && !rd_stat);
      status_q[1] <= pause_evt || (status_q[1] && !rd_stat);
    end
  end

  assign irq = (status_q[0] && cmd_q[16]) || (status_q[1] && cmd_q[17]);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CLK:   reg_rdata = clk_cfg_q;
      A_RUN:   reg_rdata = run_cfg_q;
      A_CMD:   reg_rdata = cmd_q;
      A_RX:    reg_rdata = rx_empty ? 32'd0 : rx_head;
      A_STAT:  reg_rdata = {30'd0, status_q};
      default: reg_rdata = '0;
    endcase
  end

  spi_pkt_fifo #(.WIDTH(32), .DEPTH(WORDS)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .push(wr_tx), .din(reg_wdata),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full));

  spi_pkt_fifo #(.WIDTH(32), .DEPTH(WORDS)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .push(rx_push), .din(rx_merged),
    .pop(rd_rx), .dout(rx_head), .empty(rx_empty), .full(rx_full));

  spi_pkt_seq #(.TW(TIME_W), .LW(LEN_W), .PW(LOOP_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .go_start(go_start), .go_resume(go_resume),
    .sck_act(clk_cfg_q[7:0]), .sck_idl(clk_cfg_q[15:8]),
    .cs_hold(clk_cfg_q[23:16]), .cs_setup(clk_cfg_q[31:24]),
    .pkt_len(run_cfg_q[9:0]), .loops(run_cfg_q[23:16]), .cs_idle(run_cfg_q[31:24]),
    .cpha(cmd_q[8]), .cpol(cmd_q[9]), .tx_msb(cmd_q[12]), .rx_msb(cmd_q[13]),
    .pause_en(cmd_q[4]),
    .tx_byte(tx_byte), .tx_take(tx_take), .rx_byte(rx_byte), .rx_put(rx_put),
    .run_end(run_end), .fin_evt(fin_evt), .pause_evt(pause_evt),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  AST_STATUS_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !fin_evt && !pause_evt) |=> (status_q == 2'b00)); // R10
  AST_FINISH_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[0]) |-> $past(fin_evt)); // R10
  AST_TX_WORD_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_end && !soft_rst) |=> (txp_q == 2'd0)); // R12
endmodule

// File: tb/spi_pkt_master_tb.sv
module spi_pkt_master_tb_top;
  import spi_pkt_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, sck, cs_n, mosi, miso;
  int pass_n = 0, fail_n = 0;

  assign miso = mosi; // loopback

  always #2 clk = ~clk; // 4 time units: 250 MHz at 1 ns units

  spi_pkt_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso));

  // vector table: command, run shape, tx word, expected rx word
  localparam int NV = 6;
  localparam logic [31:0] V_CMD [NV] = '{32'h3000, 32'h3100, 32'h1200, 32'h8300, 32'hC000, 32'h7300};
  localparam logic [31:0] V_RUN [NV] = '{32'h3, 32'h0001_0001, 32'h3, 32'h3, 32'h0003_0000, 32'h3};
  localparam logic [31:0] V_TX  [NV] = '{32'hA1B2C3D4, 32'h0F1E2D3C, 32'hA1B2C3D4,
                                         32'h12345678, 32'h12345678, 32'hA1B2C3D4};
  localparam logic [31:0] V_EXP [NV] = '{32'hA1B2C3D4, 32'h0F1E2D3C, 32'h854DC32B,
                                         32'h78563412, 32'h12345678, 32'hD4C3B2A1};

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    if (act === exp) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic idle_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fail_n++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int pre, hi, tot, gap;
    idle_n(3);
    rst_n = 1'b1;
    idle_n(2);

    // R1 reset state
    check("R1", "cs_n after reset", {31'd0, cs_n}, 32'd1);
    check("R1", "sck after reset", {31'd0, sck}, 32'd0);
    check("R1", "irq after reset", {31'd0, irq}, 32'd0);
    rd(A_STAT, d); check("R1", "status after reset", d, 32'd0);

    // table walk: modes, bit order, lane order, packet shapes (R4 R5 R6 R7)
    for (int i = 0; i < NV; i++) begin
      wr(A_CMD, 32'h4);
      wr(A_CLK, 32'h0);
      wr(A_RUN, V_RUN[i]);
      wr(A_TX, V_TX[i]);
      wr(A_CMD, V_CMD[i] | 32'h0001_0001);
      wait_irq();
      rd(A_STAT, d); check("R10", $sformatf("vec %0d finish status", i), d, 32'd1);
      rd(A_RX, d);   check("R6", $sformatf("vec %0d rx word (R5 R7 R4)", i), d, V_EXP[i]);
      check("R5", $sformatf("vec %0d sck rest level", i), {31'd0, sck}, {31'd0, V_CMD[i][9]});
    end

    // R2 R3 timing: setup 3, hold 4, idle-level 2, active-level 1, cs idle 5
    wr(A_CMD, 32'h4);
    wr(A_CLK, 32'h0304_0201);
    wr(A_RUN, 32'h0500_0000);
    wr(A_TX, 32'h0000_00C3);
    wr(A_CMD, 32'h0001_3001);
    pre = 0; hi = 0; gap = 0;
    while (!cs_n && !sck) begin pre++; @(negedge clk); end
    while (sck) begin hi++; @(negedge clk); end
    tot = pre + hi;
    while (!cs_n) begin tot++; @(negedge clk); end
    while (!irq) begin gap++; @(negedge clk); end
    check("R3", "setup plus first idle half", pre, 32'd7);
    check("R2", "active-level half", hi, 32'd2);
    check("R3", "cs low window", tot, 32'd4 + 8 * (3 + 2) + 5);
    check("R3", "cs idle gap before finish", gap, 32'd6);
    rd(A_STAT, d);
    rd(A_RX, d); check("R6", "timing run data", d, 32'h0000_00C3);

    // R4 R12: 6-byte run, partial words
    wr(A_CMD, 32'h4);
    wr(A_CLK, 32'h0);
    wr(A_RUN, 32'h0001_0002);
    wr(A_TX, 32'h4433_2211);
    wr(A_TX, 32'hDDCC_BBAA);
    wr(A_CMD, 32'h0001_3001);
    wait_irq();
    rd(A_STAT, d);
    rd(A_RX, d); check("R4", "first rx word of 6", d, 32'h4433_2211);
    rd(A_RX, d); check("R12", "padded second rx word", d, 32'h0000_BBAA);
    rd(A_RX, d); check("R12", "empty rx reads zero", d, 32'd0);
    wr(A_RUN, 32'h0);
    wr(A_TX, 32'h0000_0055);
    wr(A_CMD, 32'h0001_3001);
    wait_irq();
    rd(A_STAT, d);
    rd(A_RX, d); check("R12", "partial tx word discarded", d, 32'h0000_0055);

    // R9 pause then resume
    wr(A_CMD, 32'h4);
    wr(A_RUN, 32'h0);
    wr(A_TX, 32'h11);
    wr(A_TX, 32'h22);
    wr(A_CMD, 32'h0003_0011);
    wait_irq();
    check("R9", "cs held while paused", {31'd0, cs_n}, 32'd0);
    rd(A_STAT, d); check("R9", "pause status bit", d, 32'd2);
    check("R10", "irq low after status read", {31'd0, irq}, 32'd0);
    rd(A_STAT, d); check("R10", "status cleared by read", d, 32'd0);
    wr(A_CMD, 32'h0003_0011);
    idle_n(10);
    check("R8", "start ignored in pause", {31'd0, cs_n}, 32'd0);
    check("R8", "no event from start in pause", {31'd0, irq}, 32'd0);
    wr(A_CMD, 32'h0003_0002);
    wait_irq();
    check("R9", "cs released after resumed run", {31'd0, cs_n}, 32'd1);
    rd(A_STAT, d); check("R9", "finish after resume", d, 32'd1);
    rd(A_RX, d); check("R9", "byte before pause", d, 32'h11);
    rd(A_RX, d); check("R9", "byte after resume", d, 32'h22);

    // R11 masked interrupt
    wr(A_TX, 32'h05);
    wr(A_CMD, 32'h1);
    idle_n(40);
    check("R11", "irq masked", {31'd0, irq}, 32'd0);
    check("R11", "run finished", {31'd0, cs_n}, 32'd1);
    rd(A_STAT, d); check("R11", "masked event still in status", d, 32'd1);
    rd(A_RX, d); check("R11", "masked run data", d, 32'h05);

    // R8 resume ignored in idle
    wr(A_CMD, 32'h2);
    idle_n(5);
    check("R8", "resume ignored in idle", {31'd0, cs_n}, 32'd1);

    // R8 soft reset mid-run
    wr(A_CLK, 32'h1010_1010);
    wr(A_RUN, 32'h3);
    wr(A_TX, 32'hFFFF_FFFF);
    wr(A_CMD, 32'h0001_0001);
    idle_n(10);
    check("R8", "cs low mid-run", {31'd0, cs_n}, 32'd0);
    wr(A_CMD, 32'h4);
    check("R8", "soft reset releases cs", {31'd0, cs_n}, 32'd1);
    idle_n(200);
    check("R8", "no interrupt after soft reset", {31'd0, irq}, 32'd0);
    rd(A_STAT, d); check("R8", "status after soft reset", d, 32'd0);
    rd(A_RX, d); check("R8", "rx emptied by soft reset", d, 32'd0);

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule